// File: doc/BRIEF.md
# Single-Line Trigger-Configurable Interrupt Controller

This block watches one external interrupt line, for example the alert pin of a power-management chip. It turns that line into one request for a parent interrupt controller. A 2-bit trigger code selects the detection mode:

- Bit 0 of the code chooses edge detection (1) or level detection (0).
- Bit 1 of the code chooses the active polarity: high or rising (1), low or falling (0).

Detected events are latched in a pending bit. Software clears that bit by writing an acknowledge. An enable bit decides whether the pending bit reaches the request output.

Software reaches the block through a plain 32-bit register port. The port has a write strobe, a read strobe and byte offsets. Reads are combinational. Writes take effect at the clock edge. A parameter chooses one of two register layouts, so the same block fits either address map.

The external line is asynchronous. It passes through a synchroniser chain before any detection. A typical bring-up sequence is:

1. Clear enable.
2. Acknowledge any stale pending state.
3. Program the trigger code.
4. Set enable.

Top module: `irq_line_ctrl`

## Requirements
- R1: After reset the trigger code is 0, enable is 0, and `irq_out` is 0. With the line at its idle level (`IDLE_LEVEL`, default 1) the pending bit reads 0.
- R2: The control register holds the trigger code in bits [1:0]. Code 0 is low level, 1 is falling edge, 2 is high level and 3 is rising edge. The code reads back as written.
- R3: The line passes through `SYNC_STAGES` flops (default 2). Take a change of `irq_in` that is applied between clock edges. The pending bit it causes is not visible after the second following edge. It is visible after the third.
- R4: In edge modes, pending sets only on the selected edge. The opposite edge does not set it. Pending then stays set until it is acknowledged.
- R5: In level modes, pending is set again on every cycle in which the line is at its active level. An acknowledge during the active level has no lasting effect. An acknowledge after the line returns inactive clears pending.
- R6: Writing 1 to bit 0 of the pending register clears pending. Writing 0 there has no effect.
- R7: Bit 0 of the enable register gates the output, so `irq_out` equals pending AND enable. Pending still latches while enable is 0.
- R8: If an acknowledge and a new event fall in the same cycle, pending ends up set.
- R9: With `MAP_SEL`=0 the control, pending and enable registers sit at byte offsets 0x00, 0x04 and 0x08. With `MAP_SEL`=1 they sit at 0x0C, 0x10 and 0x40.
- R10: Register bits other than those named above read 0 and ignore writes. Offsets that hold no register read 0 and ignore writes. `rdata` is 0 while `rd_en` is low.
- R11: Writing a new trigger code does not by itself clear pending. The new code governs detection from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 1 | Asynchronous external interrupt line |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational, zero when no read |
| irq_out | output | 1 | Request to the parent controller |

## Verification
Two functions can land on the same clock edge: a detected event and a software acknowledge. To provoke the collision in rising-edge mode, the bench raises the line and then counts two edges through the synchroniser. It presents the acknowledge write on exactly the edge where the event is registered. Pending must read 1 afterwards.

The same pairing also appears in the level modes. There an acknowledge issued while the line is still active must leave pending set. Each of the four trigger codes is swept through the same script, and expected values are derived from the code's two bits.

// File: rtl/irq_line_pkg.sv
package irq_line_pkg;

   typedef enum logic [1:0] {
      TRIG_LOW_LVL  = 2'd0,
      TRIG_FALL     = 2'd1,
      TRIG_HIGH_LVL = 2'd2,
      TRIG_RISE     = 2'd3
   } trig_e;

   localparam int NUM_MAPS = 2;

   // layout A
   localparam logic [7:0] MAPA_CTRL = 8'h00;
   localparam logic [7:0] MAPA_PEND = 8'h04;
   localparam logic [7:0] MAPA_EN   = 8'h08;
   // layout B
   localparam logic [7:0] MAPB_CTRL = 8'h0C;
   localparam logic [7:0] MAPB_PEND = 8'h10;
   localparam logic [7:0] MAPB_EN   = 8'h40;

   localparam int MIN_ADDR_W = 7;

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
   parameter int   STAGES = 2,
   parameter logic IDLE   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic lvl_d
);

   if (STAGES < 2) begin : g_bad_stages
      $error("irq_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{IDLE}};
         prev_q  <= IDLE;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign lvl   = chain_q[STAGES-1];
   assign lvl_d = prev_q;

endmodule

// File: rtl/irq_line_detect.sv
module irq_line_detect
   import irq_line_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  trig_e trig,
   input  logic  lvl,
   input  logic  lvl_d,
   input  logic  ack,
   output logic  pending
);

   logic is_edge;
   logic active_hi;
   logic edge_hit;
   logic level_hit;
   logic evt;
   logic pend_q;

   assign is_edge   = trig[0];
   assign active_hi = trig[1];
   assign edge_hit  = active_hi ? (lvl & ~lvl_d) : (~lvl & lvl_d);
   assign level_hit = (lvl == active_hi);
   assign evt       = is_edge ? edge_hit : level_hit;

   // new event has priority over the acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= evt | (pend_q & ~ack);
   end

   assign pending = pend_q;

   AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig == TRIG_RISE && $rose(lvl)) |=> pending); // R4
   AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig == TRIG_FALL && $fell(lvl)) |=> pending); // R4
   AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig[0] && pending && !ack) |=> pending); // R4
   AST_LEVEL_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig[0] && lvl == trig[1]) |=> pending); // R5
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && trig[0] && $stable(lvl)) |=> !pending); // R6

endmodule

// File: rtl/irq_line_regs.sv
module irq_line_regs
   import irq_line_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 8,
   parameter int MAP_SEL = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              pending_in,
   output trig_e             trig,
   output logic              en,
   output logic              ack
);

   if (MAP_SEL < 0 || MAP_SEL >= NUM_MAPS) begin : g_bad_map
      $error("irq_line_regs: MAP_SEL out of range");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("irq_line_regs: ADDR_W too narrow for the register layout");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("irq_line_regs: DATA_W must be at least 2");
   end

   logic [ADDR_W-1:0] off_ctrl;
   logic [ADDR_W-1:0] off_pend;
   logic [ADDR_W-1:0] off_en;

   if (MAP_SEL == 1) begin : g_map_b
      assign off_ctrl = ADDR_W'(MAPB_CTRL);
      assign off_pend = ADDR_W'(MAPB_PEND);
      assign off_en   = ADDR_W'(MAPB_EN);
   end else begin : g_map_a
      assign off_ctrl = ADDR_W'(MAPA_CTRL);
      assign off_pend = ADDR_W'(MAPA_PEND);
      assign off_en   = ADDR_W'(MAPA_EN);
   end

   logic  hit_ctrl, hit_pend, hit_en;
   trig_e trig_q;
   logic  en_q;
   logic  unused_wdata;

   assign hit_ctrl     = (addr == off_ctrl);
   assign hit_pend     = (addr == off_pend);
   assign hit_en       = (addr == off_en);
   assign unused_wdata = ^wdata[DATA_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= TRIG_LOW_LVL;
         en_q   <= 1'b0;
      end else if (wr_en) begin
         if (hit_ctrl) trig_q <= trig_e'(wdata[1:0]);
         if (hit_en)   en_q   <= wdata[0];
      end
   end

   assign ack  = wr_en & hit_pend & wdata[0];
   assign trig = trig_q;
   assign en   = en_q;

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (hit_ctrl)      rdata[1:0] = trig_q;
         else if (hit_pend) rdata[0]   = pending_in;
         else if (hit_en)   rdata[0]   = en_q;
      end
   end

   AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == off_ctrl) |=> (trig == $past(wdata[1:0]))); // R2
   AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == off_en) |=> (en == $past(wdata[0]))); // R7
   AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == off_en) |=> $stable(en)); // R10

endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
   import irq_line_pkg::*;
#(
   parameter int   DATA_W      = 32,
   parameter int   ADDR_W      = 8,
   parameter int   MAP_SEL     = 0,
   parameter int   SYNC_STAGES = 2,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_in,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_out
);

   logic  lvl, lvl_d;
   logic  pending;
   logic  en_q;
   logic  ack;
   trig_e trig;

   irq_line_sync #(
      .STAGES (SYNC_STAGES),
      .IDLE   (IDLE_LEVEL)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (irq_in),
      .lvl   (lvl),
      .lvl_d (lvl_d)
   );

   irq_line_detect u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig    (trig),
      .lvl     (lvl),
      .lvl_d   (lvl_d),
      .ack     (ack),
      .pending (pending)
   );

   irq_line_regs #(
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .MAP_SEL (MAP_SEL)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .rd_en      (rd_en),
      .addr       (addr),
      .wdata      (wdata),
      .rdata      (rdata),
      .pending_in (pending),
      .trig       (trig),
      .en         (en_q),
      .ack        (ack)
   );

   assign irq_out = pending & en_q;

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wdata[0] && ack == 1'b0 && $past(!en_q) && !en_q) |-> !irq_out); // R7
   AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && trig[0] && $stable(lvl)) |=> !irq_out); // R6

endmodule

// File: tb/irq_line_ctrl_bench.sv
`timescale 1ns/1ps
module irq_line_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_in = 1'b1;
   logic        wr_en [2];
   logic        rd_en [2];
   logic [7:0]  addr  [2];
   logic [31:0] wdata [2];
   logic [31:0] rdata [2];
   logic        irq_out [2];

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   irq_line_ctrl #(.MAP_SEL(0)) u_irq_line_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .wr_en(wr_en[0]), .rd_en(rd_en[0]), .addr(addr[0]),
      .wdata(wdata[0]), .rdata(rdata[0]), .irq_out(irq_out[0]));

   irq_line_ctrl #(.MAP_SEL(1)) u_irq_line_ctrl_alt (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .wr_en(wr_en[1]), .rd_en(rd_en[1]), .addr(addr[1]),
      .wdata(wdata[1]), .rdata(rdata[1]), .irq_out(irq_out[1]));

   // r: 0 control, 1 pending, 2 enable
   function automatic logic [7:0] offs(input int d, input int r);
      if (d == 0) return (r == 0) ? 8'h00 : (r == 1) ? 8'h04 : 8'h08;
      else        return (r == 0) ? 8'h0C : (r == 1) ? 8'h10 : 8'h40;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_raw(input int d, input logic [7:0] a, input logic [31:0] v);
      @(negedge clk);
      addr[d] = a; wdata[d] = v; wr_en[d] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en[d] = 1'b0; wdata[d] = '0;
   endtask

   task automatic wr(input int d, input int r, input logic [31:0] v);
      wr_raw(d, offs(d, r), v);
   endtask

   task automatic rd_raw(input int d, input logic [7:0] a, output logic [31:0] v);
      addr[d] = a; rd_en[d] = 1'b1;
      #1;
      v = rdata[d];
      rd_en[d] = 1'b0;
   endtask

   task automatic rd(input int d, input int r, output logic [31:0] v);
      rd_raw(d, offs(d, r), v);
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      for (int d = 0; d < 2; d++) begin
         wr_en[d] = 0; rd_en[d] = 0; addr[d] = 0; wdata[d] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      clks(4);

      // R1 reset state
      for (int d = 0; d < 2; d++) begin
         rd(d, 0, v); chk("R1 ctrl", v, 0);
         rd(d, 1, v); chk("R1 pend", v, 0);
         rd(d, 2, v); chk("R1 en", v, 0);
         chk("R1 irq_out", {31'b0, irq_out[d]}, 0);
      end

      // sweep all trigger codes on layout A
      for (int m = 0; m < 4; m++) begin
         logic pol, edg, start;
         pol = m[1]; edg = m[0]; start = ~pol;
         wr(0, 2, 0);
         @(negedge clk); irq_in = start;
         clks(5);
         wr(0, 0, m);
         rd(0, 0, v); chk("R2 code readback", v, m);
         clks(4);
         wr(0, 1, 1);
         rd(0, 1, v); chk("R6 ack clears", v, 0);
         chk("R7 idle out", {31'b0, irq_out[0]}, 0);

         wr(0, 2, 1);
         @(negedge clk); irq_in = ~start;
         @(posedge clk); @(posedge clk); @(negedge clk);
         rd(0, 1, v); chk("R3 not yet", v, 0);
         @(posedge clk); @(negedge clk);
         rd(0, 1, v); chk(edg ? "R4 edge sets" : "R5 level sets", v, 1);
         chk("R7 out follows", {31'b0, irq_out[0]}, 1);

         wr(0, 1, 1);
         rd(0, 1, v); chk(edg ? "R4 ack edge" : "R5 ack while active", v, edg ? 0 : 1);

         @(negedge clk); irq_in = start;
         clks(4);
         rd(0, 1, v); chk(edg ? "R4 opposite edge" : "R5 latched", v, edg ? 0 : 1);
         wr(0, 1, 1);
         rd(0, 1, v); chk("R5 ack after inactive", v, 0);

         wr(0, 2, 0);
         @(negedge clk); irq_in = ~start;
         clks(4);
         rd(0, 1, v); chk("R7 latch while disabled", v, 1);
         chk("R7 masked out", {31'b0, irq_out[0]}, 0);
         wr(0, 2, 1);
         chk("R7 unmask out", {31'b0, irq_out[0]}, 1);
         wr(0, 1, 0);
         rd(0, 1, v); chk("R6 write zero", v, 1);
         wr(0, 1, 1);
         rd(0, 1, v); chk("R6 ack in mode", v, edg ? 0 : 1);
         @(negedge clk); irq_in = start;
         clks(4);
         wr(0, 1, 1);
         rd(0, 1, v); chk("R6 final clear", v, 0);
      end

      // R11 change of code keeps pending
      wr(0, 2, 1);
      wr(0, 0, 3);
      @(negedge clk); irq_in = 1'b0;
      clks(4);
      wr(0, 1, 1);
      @(negedge clk); irq_in = 1'b1;
      clks(4);
      rd(0, 1, v); chk("R11 set by rise", v, 1);
      wr(0, 0, 1);
      clks(3);
      rd(0, 1, v); chk("R11 kept after code change", v, 1);
      wr(0, 1, 1);
      rd(0, 1, v); chk("R11 ack", v, 0);
      @(negedge clk); irq_in = 1'b0;
      clks(4);
      rd(0, 1, v); chk("R11 new code active", v, 1);

      // R8 event and acknowledge on the same edge
      wr(0, 0, 3);
      wr(0, 1, 1);
      rd(0, 1, v); chk("R8 precondition", v, 0);
      @(negedge clk); irq_in = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      addr[0] = offs(0, 1); wdata[0] = 1; wr_en[0] = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en[0] = 1'b0; wdata[0] = 0;
      rd(0, 1, v); chk("R8 set wins", v, 1);
      wr(0, 1, 1);

      // R10 unused bits and holes
      wr(0, 0, 32'hFFFF_FFFC);
      rd(0, 0, v); chk("R10 ctrl upper bits", v, 0);
      wr(0, 2, 32'hFFFF_FFFE);
      rd(0, 2, v); chk("R10 en upper bits", v, 0);
      wr_raw(0, 8'h14, 32'hFFFF_FFFF);
      rd_raw(0, 8'h14, v); chk("R10 hole reads zero", v, 0);
      rd(0, 0, v); chk("R10 hole write ignored", v, 0);
      addr[0] = offs(0, 0); #1;
      chk("R10 no read strobe", rdata[0], 0);

      // R9 layout B
      wr_raw(1, 8'h08, 1);
      rd(1, 2, v); chk("R9 layout B ignores A enable", v, 0);
      rd_raw(1, 8'h00, v); chk("R9 layout B hole at 0", v, 0);
      wr(1, 0, 3);
      rd(1, 0, v); chk("R9 layout B ctrl", v, 3);
      wr(1, 2, 1);
      rd(1, 2, v); chk("R9 layout B en", v, 1);
      @(negedge clk); irq_in = 1'b0;
      clks(4);
      wr(1, 1, 1);
      @(negedge clk); irq_in = 1'b1;
      clks(4);
      rd(1, 1, v); chk("R9 layout B pend", v, 1);
      chk("R9 layout B out", {31'b0, irq_out[1]}, 1);
      wr(1, 1, 1);
      rd(1, 1, v); chk("R9 layout B ack", v, 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule